// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds the machine-level performance counters of a 64-bit core. It keeps a 64-bit cycle counter that never stops and a 64-bit counter of retired instructions. It also keeps a bank of 64-bit programmable counters, indexed 3 and up. Each programmable counter has its own event selector, and the code held in that selector picks which input of the event vector the counter counts. Typical event sources are the stall signals of an attached accelerator, such as a stall on data movement or a stall on response backpressure.

Software reaches the registers through a plain CSR port: a 12-bit address, read and write strobes, 64-bit write data and 64-bit read data. Read data follows the address combinationally. A flag marks accesses the block does not accept. Three read-only aliases give user code a view of the cycle counter, of the retired-instruction counter, and of a real-time value supplied from outside the block.

Top module: `perfmon_csr_unit`

## Requirements
- R1: After reset, every counter and every event selector reads zero.
- R2: The cycle counter at address 0xB00 increases by one on every clock edge. It wraps from all ones to zero.
- R3: The retired-instruction counter at address 0xB02 increases by one only on edges where `retire_i` is high. Otherwise it holds its value.
- R4: Programmable counter n (n from 3 to 2+NUM_PROG) sits at address 0xB00+n, and its selector sits at 0x320+n. Selector n drives only counter n.
- R5: A programmable counter increases on an edge when its selector holds code k, with 1 ≤ k ≤ NUM_EVT, and `evt_i[k-1]` is high. Code 1 selects bit 0 (DMA stall) and code 2 selects bit 1 (response stall). Code 0, or any code above NUM_EVT, makes the counter hold its value.
- R6: A selector stores the low SEL_W (8) bits of the write data. Its upper bits always read as zero.
- R7: A read of 0xC00 returns the cycle count, a read of 0xC01 returns `rtc_i`, and a read of 0xC02 returns the retired-instruction count.
- R8: A write to 0xC00, 0xC01 or 0xC02 raises `csr_illegal_o` in that cycle and changes no register.
- R9: When a CSR write to a counter and an increment of that counter fall on the same edge, the counter takes the written value and the increment is lost.
- R10: An access (read or write) to an address outside the map raises `csr_illegal_o`. Such a read returns zero, and such a write changes no register.
- R11: `csr_illegal_o` is low whenever neither strobe is high. It is also low for a legal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_re_i | input | 1 | Read strobe |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data, combinational from the address |
| csr_illegal_o | output | 1 | The access is rejected |
| retire_i | input | 1 | One instruction retires this cycle |
| evt_i | input | NUM_EVT | Event vector; bit k-1 is matched by selector code k |
| rtc_i | input | 64 | External real-time value |

## Verification
The bench loads all ones into the cycle counter and reads it on the next edge. A design that does not wrap, or that saturates, returns something other than zero there. It programs selectors with code 0 and with a code above the event count, and it places a selector on the last counter in the bank. A design with an off-by-one in the code-to-bit mapping, or in the address-to-index mapping, counts the wrong stall or no stall at all. It writes a counter while that counter's event is high. A design that lets the increment win returns the written value plus one. It also writes to the aliases and to unmapped addresses. A design that accepts those writes changes a counter or a selector, and a design that does not flag them leaves the illegal flag low.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned AW   = 12;

  localparam logic [AW-1:0] A_MCYCLE   = 12'hB00;
  localparam logic [AW-1:0] A_MINSTRET = 12'hB02;
  localparam logic [AW-1:0] A_HPM_BASE = 12'hB03;
  localparam logic [AW-1:0] A_SEL_BASE = 12'h323;
  localparam logic [AW-1:0] A_U_CYCLE  = 12'hC00;
  localparam logic [AW-1:0] A_U_RTC    = 12'hC01;
  localparam logic [AW-1:0] A_U_INSTR  = 12'hC02;

  // Address of bank entry idx, counted from a base
  function automatic logic [AW-1:0] bank_addr(logic [AW-1:0] base, int unsigned idx);
    return base + AW'(idx);
  endfunction

  // True for the read-only user aliases
  function automatic logic is_alias(logic [AW-1:0] a);
    return (a == A_U_CYCLE) || (a == A_U_RTC) || (a == A_U_INSTR);
  endfunction
endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  function automatic logic [W-1:0] step(logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wr_i)  q_o <= wdata_i;
    else if (inc_i) q_o <= step(q_o);
  end

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(wdata_i)); // R9
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && inc_i) |=> q_o == $past(q_o) + W'(1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !inc_i) |=> $stable(q_o)); // R3
endmodule

// File: rtl/perfmon_evt_match.sv
module perfmon_evt_match #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned SEL_W   = 8
) (
  input  logic [SEL_W-1:0]   code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int k = 1; k <= NUM_EVT; k++) begin
      if (code_i == SEL_W'(k)) hit_o = evt_i[k-1];
    end
  end

  always_comb begin
    if (code_i == '0) AST_CODE0_IDLE: assert (!hit_o); // R5
  end
endmodule

// File: rtl/perfmon_csr_unit.sv
module perfmon_csr_unit
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_PROG = 29,
  parameter int unsigned NUM_EVT  = 8,
  parameter int unsigned SEL_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [11:0]        csr_addr_i,
  input  logic               csr_re_i,
  input  logic               csr_we_i,
  input  logic [63:0]        csr_wdata_i,
  output logic [63:0]        csr_rdata_o,
  output logic               csr_illegal_o,
  input  logic               retire_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [63:0]        rtc_i
);
  localparam int unsigned PW = (NUM_PROG > 1) ? $clog2(NUM_PROG) : 1;

  logic [XLEN-1:0]  cyc_q, ins_q;
  logic [XLEN-1:0]  hpm_q [NUM_PROG];
  logic [SEL_W-1:0] sel_q [NUM_PROG];
  logic [NUM_PROG-1:0] hpm_hit, hpm_wr, sel_wr;

  // Named decode events
  logic wr_cyc, wr_ins, access, mapped, alias_wr;
  assign wr_cyc   = csr_we_i && (csr_addr_i == A_MCYCLE);
  assign wr_ins   = csr_we_i && (csr_addr_i == A_MINSTRET);
  assign access   = csr_re_i || csr_we_i;
  assign alias_wr = csr_we_i && is_alias(csr_addr_i);

  perfmon_counter #(.W(XLEN)) u_cyc (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(1'b1), .wr_i(wr_cyc),
    .wdata_i(csr_wdata_i), .q_o(cyc_q));

  perfmon_counter #(.W(XLEN)) u_ins (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(retire_i), .wr_i(wr_ins),
    .wdata_i(csr_wdata_i), .q_o(ins_q));

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_hpm
    assign hpm_wr[i] = csr_we_i && (csr_addr_i == bank_addr(A_HPM_BASE, i));
    assign sel_wr[i] = csr_we_i && (csr_addr_i == bank_addr(A_SEL_BASE, i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sel_q[i] <= '0;
      else if (sel_wr[i]) sel_q[i] <= csr_wdata_i[SEL_W-1:0];
    end

    perfmon_evt_match #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_match (
      .code_i(sel_q[i]), .evt_i(evt_i), .hit_o(hpm_hit[i]));

    perfmon_counter #(.W(XLEN)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(hpm_hit[i]), .wr_i(hpm_wr[i]),
      .wdata_i(csr_wdata_i), .q_o(hpm_q[i]));

    AST_SEL_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q[i] == '0 && !hpm_wr[i]) |=> $stable(hpm_q[i])); // R5
  end

  // Combinational read mux and map check
  always_comb begin
    csr_rdata_o = '0;
    mapped      = 1'b1;
    unique case (csr_addr_i)
      A_MCYCLE, A_U_CYCLE:   csr_rdata_o = cyc_q;
      A_MINSTRET, A_U_INSTR: csr_rdata_o = ins_q;
      A_U_RTC:               csr_rdata_o = rtc_i;
      default: begin
        mapped = 1'b0;
        for (int i = 0; i < NUM_PROG; i++) begin
          if (csr_addr_i == bank_addr(A_HPM_BASE, i)) begin
            mapped = 1'b1;
            csr_rdata_o = hpm_q[i];
          end
          if (csr_addr_i == bank_addr(A_SEL_BASE, i)) begin
            mapped = 1'b1;
            csr_rdata_o = {{(XLEN-SEL_W){1'b0}}, sel_q[i]};
          end
        end
      end
    endcase
  end

  assign csr_illegal_o = access && (!mapped || alias_wr);

  logic [PW-1:0] unused_pw;
  assign unused_pw = '0;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_re_i && !mapped) |-> (csr_rdata_o == '0 && csr_illegal_o)); // R10
  AST_ALIAS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_U_CYCLE) |-> csr_rdata_o == cyc_q); // R7
  AST_ALIAS_WR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_wr |-> csr_illegal_o); // R8
  AST_QUIET_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access |-> !csr_illegal_o); // R11
  AST_ALIAS_NO_CYC_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_wr |=> cyc_q == $past(cyc_q) + 64'd1); // R8
endmodule

// File: tb/test_perfmon_csr_unit.sv
module test_perfmon_csr_unit;
  localparam int NUM_PROG = 29;
  localparam int NUM_EVT  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        re = 1'b0, we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        ill;
  logic        retire = 1'b0;
  logic [NUM_EVT-1:0] evt = '0;
  logic [63:0] rtc = '0;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  perfmon_csr_unit #(.NUM_PROG(NUM_PROG), .NUM_EVT(NUM_EVT), .SEL_W(8)) i_perfmon_csr_unit (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_re_i(re), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .csr_illegal_o(ill),
    .retire_i(retire), .evt_i(evt), .rtc_i(rtc));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Combinational read at the current time, no clock edge consumed
  task automatic rd(logic [11:0] a, output logic [63:0] d, output logic f);
    addr = a; re = 1'b1; #1;
    d = rdata; f = ill;
    re = 1'b0; #1;
  endtask

  // Write lasting one clock edge; returns at the next negedge
  task automatic wr(logic [11:0] a, logic [63:0] d, output logic f);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; #1;
    f = ill;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic f;
    rd(12'hB02, d, f); check("R1 instret", d, 0);
    rd(12'hB03, d, f); check("R1 hpm3", d, 0);
    rd(12'h33F, d, f); check("R1 sel31", d, 0);
    rd(12'hB1F, d, f); check("R1 hpm31", d, 0);
  endtask

  task automatic t_cycle;
    logic [63:0] d, v; logic f;
    wr(12'hB00, 64'hFFFF_FFFF_FFFF_FFFF, f);
    check("R11 legal write flag", f, 0);
    rd(12'hB00, d, f); check("R9 cycle write", d, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    rd(12'hB00, d, f); check("R2 cycle wrap", d, 0);
    rd(12'hB00, v, f);
    repeat (7) @(negedge clk);
    rd(12'hB00, d, f); check("R2 cycle step", d, v + 7);
    rd(12'hC00, d, f); check("R7 cycle alias", d, v + 7);
  endtask

  task automatic t_instret;
    logic [63:0] d; logic f;
    wr(12'hB02, 64'd0, f);
    for (int i = 0; i < 10; i++) begin
      retire = (i % 2 == 0);
      @(negedge clk);
    end
    retire = 1'b0;
    rd(12'hB02, d, f); check("R3 instret count", d, 5);
    rd(12'hC02, d, f); check("R7 instret alias", d, 5);
    repeat (3) @(negedge clk);
    rd(12'hB02, d, f); check("R3 instret hold", d, 5);
    retire = 1'b1;
    wr(12'hB02, 64'd40, f);
    retire = 1'b0;
    rd(12'hB02, d, f); check("R9 instret write wins", d, 40);
  endtask

  task automatic t_events;
    logic [63:0] d; logic f;
    wr(12'h323, 64'd1, f);   // counter 3: DMA stall
    wr(12'h324, 64'd2, f);   // counter 4: response stall
    wr(12'h325, 64'd0, f);   // counter 5: off
    wr(12'h326, 64'd9, f);   // counter 6: no such event
    wr(12'h33F, 64'd8, f);   // counter 31: bit 7
    evt = 8'h01; repeat (3) @(negedge clk);
    evt = 8'h02; repeat (2) @(negedge clk);
    evt = 8'h03; repeat (1) @(negedge clk);
    evt = 8'h80; repeat (4) @(negedge clk);
    evt = 8'h00;
    rd(12'hB03, d, f); check("R5 dma stall count", d, 4);
    rd(12'hB04, d, f); check("R5 resp stall count", d, 3);
    rd(12'hB05, d, f); check("R5 code zero holds", d, 0);
    rd(12'hB06, d, f); check("R5 code out of range holds", d, 0);
    rd(12'hB1F, d, f); check("R4 last counter", d, 4);
    rd(12'h33F, d, f); check("R4 last selector", d, 8);
    wr(12'h327, 64'hFFFF_FF05, f);
    rd(12'h327, d, f); check("R6 selector width", d, 64'h05);
  endtask

  task automatic t_write_wins;
    logic [63:0] d; logic f;
    evt = 8'h01;
    wr(12'hB03, 64'd100, f);
    rd(12'hB03, d, f); check("R9 hpm write wins", d, 100);
    @(negedge clk);
    evt = 8'h00;
    rd(12'hB03, d, f); check("R5 hpm resumes", d, 101);
  endtask

  task automatic t_alias;
    logic [63:0] d, v, s; logic f;
    rtc = 64'h1234_5678_9ABC_DEF0;
    rd(12'hC01, d, f); check("R7 rtc alias", d, 64'h1234_5678_9ABC_DEF0);
    check("R11 alias read legal", f, 0);
    rd(12'hB00, v, f);
    @(negedge clk);
    rd(12'hB00, v, f);
    addr = 12'hC00; wdata = 64'd5; we = 1'b1; #1;
    check("R8 alias write flag", ill, 1);
    @(negedge clk); we = 1'b0;
    rd(12'hB00, d, f); check("R8 cycle unchanged", d, v + 1);
    rd(12'hB02, s, f);
    wr(12'hC02, 64'd999, f); check("R8 instret alias flag", f, 1);
    rd(12'hB02, d, f); check("R8 instret unchanged", d, s);
  endtask

  task automatic t_unmapped;
    logic [63:0] d, s; logic f;
    rd(12'hB01, d, f); check("R10 hole read data", d, 0); check("R10 hole read flag", f, 1);
    rd(12'hB20, d, f); check("R10 past bank data", d, 0); check("R10 past bank flag", f, 1);
    rd(12'h33F, s, f);
    wr(12'h340, 64'd3, f); check("R10 write flag", f, 1);
    rd(12'h33F, d, f); check("R10 neighbour unchanged", d, s);
    addr = 12'h7C0; re = 1'b0; we = 1'b0; #1;
    check("R11 idle flag", ill, 0);
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cycle();
    t_instret();
    t_events();
    t_write_wins();
    t_alias();
    t_unmapped();
    finish_up();
  end
endmodule